// File: doc/BRIEF.md
# Two-Core Store Buffer with Forwarding and Fence

Each of two cores gets a private write buffer between its request port and one shared memory. A store does not write memory. It becomes an address/data entry in its own core's queue, and the queue sends entries to memory later, one at a time, whatever the core does next. A load first searches its own core's queue. The youngest matching entry answers it in the same cycle. If nothing matches, the load reads shared memory, which never holds stores that are still waiting in the other core's queue.

A fence request waits until its core's queue is empty, so any later request from that core waits behind it. The memory has a single port. A round-robin arbiter shares it among four requesters: each core's drain and each core's load miss. Every granted access finishes in one cycle. Because of this structure, a store-buffering program can end with both cores reading 0. Inserting fences removes that outcome.

Each core uses a ready/valid request handshake. A load's data comes back in the cycle its request is accepted.

Top module: `tso_sb_pair`

## Requirements
- R1: An accepted store (op code 2'b01) only adds one entry to the issuing core's queue. Occupancy rises by one unless a drain retires an entry in the same cycle, and shared memory does not change at acceptance.
- R2: Queued entries leave in issue order, one per drain grant, and keep draining without any further request from the core. A load from another core eventually sees the last stored value, and never sees a value go backwards.
- R3: A load (op code 2'b10) whose address matches entries in its own core's queue is accepted in that cycle without a memory access. It returns the data of the youngest matching entry.
- R4: A load with no own-queue match reads shared memory when granted. It never sees entries held in the other core's queue, so cores that each store 1 to different locations can both read 0.
- R5: A fence (op code 2'b11) is accepted only in a cycle when its core's queue holds no entries. While it waits, no later request from that core proceeds.
- R6: When a queue holds DEPTH entries, a store to it is not accepted (req_ready_o low) until an entry drains.
- R7: The memory port grants at most one requester per cycle, and only a requesting one. The grant order is round-robin over core0 drain, core0 load, core1 drain, core1 load. A granted access completes in that cycle.
- R8: After reset, every shared memory location reads 0 and every queue is empty.
- R9: sb_empty_o, sb_full_o and sb_count_o report each queue's empty state, full state and occupancy.
- R10: Op code 2'b00 is a no-operation. It is accepted at once and leaves queue and memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_CORES | Request valid, one bit per core |
| req_op_i | input | N_CORES x 2 | Request op code per core |
| req_addr_i | input | N_CORES x AW | Request address per core |
| req_data_i | input | N_CORES x DW | Store data per core |
| req_ready_o | output | N_CORES | Request accepted this cycle |
| resp_valid_o | output | N_CORES | Load data valid (same cycle as acceptance) |
| resp_data_o | output | N_CORES x DW | Load data per core |
| sb_empty_o | output | N_CORES | Queue empty per core |
| sb_full_o | output | N_CORES | Queue full per core |
| sb_count_o | output | N_CORES x CW | Queue occupancy per core |

## Verification
The assertions check the following on every cycle:
- The arbiter never grants more than one requester and never grants an idle one.
- A queue is never pushed while full or popped while empty.
- An accepted store raises occupancy, and an accepted fence only ever sees an empty queue.

Other behaviours need the bench's scenarios, because they depend on data values across cores over many cycles:
- The youngest entry wins forwarding.
- The store-buffering outcome of both cores reading 0 occurs, and fences remove it.
- Drains go out in order.
- The buffer stalls when full.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_STORE = 2'b01,
    OP_LOAD  = 2'b10,
    OP_FENCE = 2'b11
  } sb_op_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] look_addr_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [IW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + IW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // scan oldest to youngest; last match wins
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int slot;
      slot = int'(rd_ptr_q) + i;
      if (slot >= DEPTH) slot = slot - DEPTH;
      if (i < int'(count_q) && addr_q[IW'(slot)] == look_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[IW'(slot)];
      end
    end
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign empty_o     = (count_q == '0);
  assign full_o      = (int'(count_q) == DEPTH);
  assign count_o     = count_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R2
  drain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> count_o == $past(count_o) - CW'(1));
endmodule

// File: rtl/sb_core_port.sv
module sb_core_port
  import tso_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          req_ready_o,
  output logic          resp_valid_o,
  output logic [DW-1:0] resp_data_o,
  output logic          drain_req_o,
  output logic [AW-1:0] drain_addr_o,
  output logic [DW-1:0] drain_data_o,
  input  logic          drain_gnt_i,
  output logic          load_req_o,
  output logic [AW-1:0] load_addr_o,
  input  logic          load_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  sb_op_e        op;
  logic          hit;
  logic [DW-1:0] hit_data;
  logic          push;

  assign op = sb_op_e'(req_op_i);

  always_comb begin
    case (op)
      OP_STORE: req_ready_o = !full_o;
      OP_LOAD:  req_ready_o = hit || load_gnt_i;
      OP_FENCE: req_ready_o = empty_o;
      default:  req_ready_o = 1'b1;
    endcase
  end

  assign push         = req_valid_i && (op == OP_STORE) && req_ready_o;
  assign load_req_o   = req_valid_i && (op == OP_LOAD) && !hit;
  assign load_addr_o  = req_addr_i;
  assign drain_req_o  = !empty_o;
  assign resp_valid_o = req_valid_i && (op == OP_LOAD) && req_ready_o;
  assign resp_data_o  = hit ? hit_data : mem_rdata_i;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_data_i),
    .pop_i       (drain_gnt_i),
    .look_addr_i (req_addr_i),
    .head_addr_o (drain_addr_o),
    .head_data_o (drain_data_o),
    .hit_o       (hit),
    .hit_data_o  (hit_data),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .count_o     (count_o)
  );

  // R1
  store_queued_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_STORE && req_ready_o && !drain_gnt_i)
      |=> count_o == $past(count_o) + CW'(1));
  // R5
  fence_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_FENCE && req_ready_o) |-> count_o == '0);
  // R2
  drain_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_gnt_i |-> drain_req_o);
endmodule

// File: rtl/sb_rr_arb.sv
module sb_rr_arb #(
  parameter int NR = 4,
  parameter int GW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NR-1:0] req_i,
  output logic [NR-1:0] gnt_o
);
  logic [GW-1:0] last_q;
  logic [GW-1:0] win;
  logic          found;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    win   = last_q;
    found = 1'b0;
    for (int i = 1; i <= NR; i++) begin
      int cand;
      cand = (int'(last_q) + i) % NR;
      if (!found && req_i[cand]) begin
        found = 1'b1;
        win   = GW'(cand);
      end
    end
    if (found) gnt_o[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= GW'(NR - 1);
    else if (found) last_q <= win;
  end

  // R7
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R7
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R7
  gnt_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/sb_shared_mem.sv
module sb_shared_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tso_sb_pair.sv
module tso_sb_pair #(
  parameter int N_CORES = 2,
  parameter int DEPTH   = 4,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_CORES-1:0]             req_valid_i,
  input  logic [N_CORES-1:0][1:0]        req_op_i,
  input  logic [N_CORES-1:0][AW-1:0]     req_addr_i,
  input  logic [N_CORES-1:0][DW-1:0]     req_data_i,
  output logic [N_CORES-1:0]             req_ready_o,
  output logic [N_CORES-1:0]             resp_valid_o,
  output logic [N_CORES-1:0][DW-1:0]     resp_data_o,
  output logic [N_CORES-1:0]             sb_empty_o,
  output logic [N_CORES-1:0]             sb_full_o,
  output logic [N_CORES-1:0][CW-1:0]     sb_count_o
);
  localparam int NR = 2 * N_CORES;

  logic [NR-1:0]                 arb_req, arb_gnt;
  logic [N_CORES-1:0]            drain_req, load_req;
  logic [N_CORES-1:0][AW-1:0]    drain_addr, load_addr;
  logic [N_CORES-1:0][DW-1:0]    drain_data;
  logic                          mem_we;
  logic [AW-1:0]                 mem_waddr, mem_raddr;
  logic [DW-1:0]                 mem_wdata, mem_rdata;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    // even slot: drain, odd slot: load miss
    assign arb_req[2*c]   = drain_req[c];
    assign arb_req[2*c+1] = load_req[c];

    sb_core_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i[c]),
      .req_op_i     (req_op_i[c]),
      .req_addr_i   (req_addr_i[c]),
      .req_data_i   (req_data_i[c]),
      .req_ready_o  (req_ready_o[c]),
      .resp_valid_o (resp_valid_o[c]),
      .resp_data_o  (resp_data_o[c]),
      .drain_req_o  (drain_req[c]),
      .drain_addr_o (drain_addr[c]),
      .drain_data_o (drain_data[c]),
      .drain_gnt_i  (arb_gnt[2*c]),
      .load_req_o   (load_req[c]),
      .load_addr_o  (load_addr[c]),
      .load_gnt_i   (arb_gnt[2*c+1]),
      .mem_rdata_i  (mem_rdata),
      .empty_o      (sb_empty_o[c]),
      .full_o       (sb_full_o[c]),
      .count_o      (sb_count_o[c])
    );
  end

  sb_rr_arb #(.NR(NR)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (arb_req),
    .gnt_o  (arb_gnt)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = '0;
    mem_wdata = '0;
    mem_raddr = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (arb_gnt[2*c]) begin
        mem_we    = 1'b1;
        mem_waddr = drain_addr[c];
        mem_wdata = drain_data[c];
      end
      if (arb_gnt[2*c+1]) mem_raddr = load_addr[c];
    end
  end

  sb_shared_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/tso_sb_pair_test.sv
`timescale 1ns/1ps
module tso_sb_pair_test;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [1:0] OPN = 2'b00, OPS = 2'b01, OPL = 2'b10, OPF = 2'b11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]          req_valid;
  logic [1:0][1:0]     req_op;
  logic [1:0][AW-1:0]  req_addr;
  logic [1:0][DW-1:0]  req_data;
  logic [1:0]          req_ready, resp_valid, sb_empty, sb_full;
  logic [1:0][DW-1:0]  resp_data;
  logic [1:0][CW-1:0]  sb_count;

  logic          v_d [2];
  logic [1:0]    o_d [2];
  logic [AW-1:0] a_d [2];
  logic [DW-1:0] d_d [2];

  assign req_valid = {v_d[1], v_d[0]};
  assign req_op    = {o_d[1], o_d[0]};
  assign req_addr  = {a_d[1], a_d[0]};
  assign req_data  = {d_d[1], d_d[0]};

  tso_sb_pair #(.N_CORES(2), .DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_data_i(req_data), .req_ready_o(req_ready), .resp_valid_o(resp_valid),
    .resp_data_o(resp_data), .sb_empty_o(sb_empty), .sb_full_o(sb_full),
    .sb_count_o(sb_count)
  );

  int total = 0;
  int bad = 0;
  bit saw_full [2];

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    v_d[c] = v; o_d[c] = op; a_d[c] = a; d_d[c] = d;
  endtask

  // call at a negedge; returns at a negedge with the request retired
  task automatic issue(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd, output int waits);
    waits = 0;
    rd = '0;
    drive(c, 1'b1, op, a, d);
    forever begin
      #1;
      if (sb_full[c]) saw_full[c] = 1'b1;
      if (int'(sb_count[c]) > DEPTH)
        check(1'b0, "R9 occupancy above depth", sb_count[c], DEPTH);
      if (op == OPS && sb_full[c] && req_ready[c])
        check(1'b0, "R6 store accepted while full", req_ready[c], 0);
      if (req_ready[c]) begin
        rd = resp_data[c];
        if (op == OPF) check(sb_empty[c] == 1'b1, "R5 fence accepted with entries", sb_count[c], 0);
        break;
      end
      waits++;
      if (waits > 400) begin
        check(1'b0, "request timed out", waits, 0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    drive(c, 1'b0, OPN, '0, '0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; int w;
    check(sb_empty == 2'b11, "R8 queues empty after reset", sb_empty, 3);
    check(sb_full == 2'b00 && sb_count == '0, "R9 status after reset", sb_count, 0);
    issue(1, OPL, 8'h33, '0, rd, w);
    check(rd == 0, "R8 memory reads zero", rd, 0);
    issue(0, OPL, 8'hff, '0, rd, w);
    check(rd == 0, "R8 top location reads zero", rd, 0);
  endtask

  task automatic t_nop();
    logic [DW-1:0] rd; int w;
    issue(0, OPN, 8'h44, 32'hdead, rd, w);
    check(w == 0, "R10 no-op accepted at once", w, 0);
    #1;
    check(sb_count[0] == 0 && sb_empty[0], "R10 no-op leaves queue", sb_count[0], 0);
    issue(1, OPL, 8'h44, '0, rd, w);
    check(rd == 0, "R10 no-op leaves memory", rd, 0);
  endtask

  task automatic t_forward();
    logic [DW-1:0] rd; int w;
    issue(0, OPS, 8'h10, 32'h0000_aaaa, rd, w);
    #1;
    check(sb_count[0] == 1 && !sb_empty[0], "R9 occupancy after store", sb_count[0], 1);
    issue(0, OPS, 8'h10, 32'h0000_bbbb, rd, w);
    issue(0, OPL, 8'h10, '0, rd, w);
    check(rd == 32'h0000_bbbb, "R3 youngest store forwarded", rd, 32'h0000_bbbb);
    check(w == 0, "R3 forwarded load needs no grant", w, 0);
    issue(0, OPF, '0, '0, rd, w);
    issue(1, OPL, 8'h10, '0, rd, w);
    check(rd == 32'h0000_bbbb, "R2 drained value in memory", rd, 32'h0000_bbbb);
  endtask

  task automatic t_store_buffering();
    logic [DW-1:0] ra, rb, rd; int wa, wb;
    fork
      begin
        for (int k = 0; k < 3; k++) issue(0, OPS, AW'(8'hc0 + k), 32'h7, rd, wa);
        issue(0, OPS, 8'h20, 32'h1, rd, wa);
        issue(0, OPL, 8'h21, '0, ra, wa);
      end
      begin
        for (int k = 0; k < 3; k++) issue(1, OPS, AW'(8'hd0 + k), 32'h9, rd, wb);
        issue(1, OPS, 8'h21, 32'h1, rd, wb);
        issue(1, OPL, 8'h20, '0, rb, wb);
      end
    join
    check(ra == 0, "R4 core0 misses core1 pending store", ra, 0);
    check(rb == 0, "R4 core1 misses core0 pending store", rb, 0);
    fork
      begin issue(0, OPF, '0, '0, rd, wa); issue(0, OPL, 8'h21, '0, ra, wa); end
      begin issue(1, OPF, '0, '0, rd, wb); issue(1, OPL, 8'h20, '0, rb, wb); end
    join
    check(ra == 1 && rb == 1, "R5 fenced loads see both stores", {ra[15:0], rb[15:0]}, 32'h0001_0001);
  endtask

  task automatic t_order();
    logic [DW-1:0] rd, prev; int w, wf;
    bit mono = 1'b1;
    prev = '0;
    fork
      begin
        for (int k = 1; k <= 3; k++) issue(0, OPS, 8'h40, DW'(k), rd, w);
        issue(0, OPF, '0, '0, rd, wf);
      end
      begin
        for (int k = 0; k < 8; k++) begin
          issue(1, OPL, 8'h40, '0, rd, w);
          if (rd < prev || rd > 3) mono = 1'b0;
          prev = rd;
        end
      end
    join
    check(mono, "R2 other core sees stores in order", prev, 3);
    issue(1, OPL, 8'h40, '0, rd, w);
    check(rd == 3, "R2 last store wins after drain", rd, 3);
  endtask

  task automatic t_full();
    logic [DW-1:0] rd; int w0, w1;
    saw_full[0] = 1'b0; saw_full[1] = 1'b0;
    fork
      begin
        for (int k = 0; k < 10; k++) issue(0, OPS, AW'(8'h80 + k), DW'(32'h100 + k), rd, w0);
        issue(0, OPF, '0, '0, rd, w0);
      end
      begin
        for (int k = 0; k < 10; k++) issue(1, OPS, AW'(8'h90 + k), DW'(32'h200 + k), rd, w1);
        issue(1, OPF, '0, '0, rd, w1);
      end
    join
    check(saw_full[0] && saw_full[1], "R6 both queues reached full", {saw_full[1], saw_full[0]}, 3);
    check(w0 > 0 && w1 > 0, "R5 fence waited for drain", w0, 1);
    #1;
    check(sb_empty == 2'b11 && sb_count == '0, "R9 empty after fences", sb_count, 0);
    issue(1, OPL, 8'h89, '0, rd, w0);
    check(rd == 32'h109, "R6 stalled store completed", rd, 32'h109);
  endtask

  task automatic t_arb();
    logic [DW-1:0] r0, r1; int w0, w1;
    fork
      issue(0, OPL, 8'h90, '0, r0, w0);
      issue(1, OPL, 8'h81, '0, r1, w1);
    join
    check(w0 + w1 == 1, "R7 one load served per cycle", w0 + w1, 1);
    check(r0 == 32'h200 && r1 == 32'h101, "R7 granted loads return memory", r0, 32'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(0, 1'b0, OPN, '0, '0);
    drive(1, 1'b0, OPN, '0, '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_forward();
    t_store_buffering();
    t_order();
    t_full();
    t_arb();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule